// File: doc/BRIEF.md
# Sampling Phase Sweep Controller

This block tunes the sampling instant of an external pixel clock generator. On a start command it walks a 5-bit phase code upward from 0 to 31. At each code it measures picture sharpness, then settles on one code and drives it out. Sharpness is the sum of absolute differences between consecutive valid pixels, taken over every colour channel that is not switched off. A phase that lands on pixel centres gives large swings. A phase that lands on transitions smears them.

Each code is held for a whole number of frame-sync intervals. The interval count is 28 in fast mode and 64 in slow mode. After the last code the controller applies either the code with the largest metric or the code with the smallest one, depending on an option bit. A further bit chooses when a new code reaches the output. It can be driven as soon as it is known, or held back until the next frame-sync leading edge so the change never lands inside visible lines. A synchronous soft reset returns every state machine in the block to idle.

Top module: `phase_search`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next clock. During the search `phaseCode` visits 0, 1, 2, … 31 in ascending order, one step per code, before the final code is applied.
- R2: Each code is measured over whole `vsync` intervals, bounded by `vsync` rising edges. There are 28 intervals when `slowMode`=0 and 64 when `slowMode`=1.
- R3: The metric of a code is the sum, over consecutive `pixValid` samples in its window, of |current − previous| for each enabled colour. The first sample of a window has no predecessor and adds nothing.
- R4: With `pickWorst`=0 the applied final code is the one with the smallest metric.
- R5: With `pickWorst`=1 the applied final code is the one with the largest metric.
- R6: When metrics are equal, the lower code is kept.
- R7: Setting `colorDis[0]` (red), `colorDis[1]` (green) or `colorDis[2]` (blue) removes that colour from the metric completely.
- R8: With `syncUpdate`=0 each new code reaches `phaseCode` two clocks after the `vsync` edge that ends the previous window. A complete search spans exactly 32×N `vsync` rising edges while `busy` is high, where N is the dwell count.
- R9: With `syncUpdate`=1, `phaseCode` changes only in the clock after a `vsync` rising edge. Measurement of a code starts at that edge, so a search spans 32×(N+1)+1 rising edges while `busy` is high.
- R10: `done` is high for exactly one clock. In that clock the final code is already on `phaseCode` and `busy` has just fallen.
- R11: While `softRst` is 1, the clock after it shows `busy`=0, `done`=0 and `phaseCode`=0, and `start` is ignored. Searching works normally after `softRst` returns to 0.
- R12: After `rstN` is released, `phaseCode`=0, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous reset of all search state |
| vsync | input | 1 | Frame sync, leading edge is the rising edge |
| pixValid | input | 1 | Pixel inputs carry a collected (unmasked) sample |
| pixRed | input | 10 | Red sample |
| pixGreen | input | 10 | Green sample |
| pixBlue | input | 10 | Blue sample |
| colorDis | input | 3 | Per-colour disable: bit 0 red, bit 1 green, bit 2 blue |
| start | input | 1 | Begin a search |
| pickWorst | input | 1 | 0 keeps the smallest metric, 1 the largest |
| slowMode | input | 1 | 0: 28-interval dwell, 1: 64-interval dwell |
| syncUpdate | input | 1 | 0: apply codes at once, 1: on next vsync edge |
| phaseCode | output | 5 | Phase code to the clock generator |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-clock pulse when the final code is applied |

## Verification
Two events can fall in the same clock: a soft reset and a start command. The bench raises both together and holds them for two clocks. It passes only if `busy` stays low and the phase stays at 0, and only if a later search that is not reset produces the correct result. A second collision is a `vsync` edge that both ends a dwell window and releases a deferred code. This one is judged by counting edges while `busy` is high and by checking that every deferred change of `phaseCode` lands in the clock after such an edge.

// File: rtl/psearch_pkg.sv
package psearch_pkg;

  // strobes from the sequencer to the measurement datapath
  typedef struct packed {
    logic clrAcc;     // start of a measurement window
    logic accEn;      // window open
    logic evalEn;     // window closed, compare against best
    logic evalFirst;  // first code of the sweep, take unconditionally
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_APPLY,
    ST_MEAS,
    ST_EVAL
  } seqState_t;

endpackage

// File: rtl/psearch_dp.sv
module psearch_dp
  import psearch_pkg::*;
#(
  parameter int PIX_W   = 10,
  parameter int PHASE_W = 5,
  parameter int ACC_W   = 32,
  parameter int N_COL   = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        softRst,
  input  dpCtrl_t                     ctl,
  input  logic                        pixValid,
  input  logic [N_COL-1:0][PIX_W-1:0] pix,
  input  logic [N_COL-1:0]            colorDis,
  input  logic                        pickWorst,
  input  logic [PHASE_W-1:0]          curPhase,
  output logic [PHASE_W-1:0]          bestPhase
);

  logic [N_COL-1:0][PIX_W-1:0] prevPix;
  logic [N_COL-1:0][PIX_W-1:0] contrib;
  logic                        havePrev;
  logic [ACC_W-1:0]            acc;
  logic [ACC_W-1:0]            stepSum;
  logic [ACC_W-1:0]            bestMetric;
  logic                        better;
  logic                        take;

  for (genvar c = 0; c < N_COL; c++) begin : gCol
    logic [PIX_W-1:0] absDiff;
    always_comb begin
      absDiff    = (pix[c] >= prevPix[c]) ? (pix[c] - prevPix[c]) : (prevPix[c] - pix[c]);
      contrib[c] = colorDis[c] ? '0 : absDiff;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      prevPix[c] <= '0;
      else if (softRst)               prevPix[c] <= '0;
      else if (ctl.accEn && pixValid) prevPix[c] <= pix[c];
    end
  end

  always_comb begin
    stepSum = '0;
    for (int c = 0; c < N_COL; c++) stepSum = stepSum + ACC_W'(contrib[c]);
  end

  always_comb begin
    better = pickWorst ? (acc > bestMetric) : (acc < bestMetric);
    take   = ctl.evalEn && (ctl.evalFirst || better);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc        <= '0;
      havePrev   <= 1'b0;
      bestMetric <= '0;
      bestPhase  <= '0;
    end else if (softRst) begin
      acc        <= '0;
      havePrev   <= 1'b0;
      bestMetric <= '0;
      bestPhase  <= '0;
    end else begin
      if (ctl.clrAcc) begin
        acc      <= '0;
        havePrev <= 1'b0;
      end else if (ctl.accEn && pixValid) begin
        havePrev <= 1'b1;
        if (havePrev) acc <= acc + stepSum;
      end
      if (take) begin
        bestMetric <= acc;
        bestPhase  <= curPhase;
      end
    end
  end

endmodule

// File: rtl/psearch_ctrl.sv
module psearch_ctrl
  import psearch_pkg::*;
#(
  parameter int PHASE_W    = 5,
  parameter int FAST_DWELL = 28,
  parameter int SLOW_DWELL = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softRst,
  input  logic               vsync,
  input  logic               start,
  input  logic               slowMode,
  input  logic               syncUpdate,
  input  logic [PHASE_W-1:0] bestPhase,
  output dpCtrl_t            ctl,
  output logic [PHASE_W-1:0] curPhase,
  output logic [PHASE_W-1:0] phaseCode,
  output logic               busy,
  output logic               done
);

  localparam int MAX_DWELL = (SLOW_DWELL > FAST_DWELL) ? SLOW_DWELL : FAST_DWELL;
  localparam int CNT_W     = $clog2(MAX_DWELL + 1);
  localparam logic [PHASE_W-1:0] LAST_PHASE = {PHASE_W{1'b1}};

  seqState_t        state;
  logic             vsPrev;
  logic             vsRise;
  logic             applyGo;
  logic             lastStep;
  logic [CNT_W-1:0] dwell;
  logic [CNT_W-1:0] dwellLim;

  always_comb begin
    vsRise        = vsync & ~vsPrev;
    applyGo       = ~syncUpdate | vsRise;
    dwellLim      = slowMode ? CNT_W'(SLOW_DWELL - 1) : CNT_W'(FAST_DWELL - 1);
    ctl.clrAcc    = (state == ST_APPLY) && applyGo && !lastStep;
    ctl.accEn     = (state == ST_MEAS);
    ctl.evalEn    = (state == ST_EVAL);
    ctl.evalFirst = (curPhase == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      vsPrev    <= 1'b0;
      curPhase  <= '0;
      phaseCode <= '0;
      lastStep  <= 1'b0;
      dwell     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else if (softRst) begin
      state     <= ST_IDLE;
      vsPrev    <= 1'b0;
      curPhase  <= '0;
      phaseCode <= '0;
      lastStep  <= 1'b0;
      dwell     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      vsPrev <= vsync;
      done   <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          curPhase <= '0;
          lastStep <= 1'b0;
          busy     <= 1'b1;
          state    <= ST_APPLY;
        end
        ST_APPLY: if (applyGo) begin
          phaseCode <= lastStep ? bestPhase : curPhase;
          dwell     <= '0;
          if (lastStep) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_MEAS;
          end
        end
        ST_MEAS: if (vsRise) begin
          if (dwell == dwellLim) state <= ST_EVAL;
          else                   dwell <= dwell + 1'b1;
        end
        ST_EVAL: begin
          if (curPhase == LAST_PHASE) lastStep <= 1'b1;
          else                        curPhase <= curPhase + 1'b1;
          state <= ST_APPLY;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phase_search.sv
module phase_search
  import psearch_pkg::*;
#(
  parameter int PIX_W      = 10,
  parameter int PHASE_W    = 5,
  parameter int ACC_W      = 32,
  parameter int FAST_DWELL = 28,
  parameter int SLOW_DWELL = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               softRst,
  input  logic               vsync,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixRed,
  input  logic [PIX_W-1:0]   pixGreen,
  input  logic [PIX_W-1:0]   pixBlue,
  input  logic [2:0]         colorDis,
  input  logic               start,
  input  logic               pickWorst,
  input  logic               slowMode,
  input  logic               syncUpdate,
  output logic [PHASE_W-1:0] phaseCode,
  output logic               busy,
  output logic               done
);

  dpCtrl_t                ctl;
  logic [PHASE_W-1:0]     curPhase;
  logic [PHASE_W-1:0]     bestPhase;
  logic [2:0][PIX_W-1:0]  pixBus;

  assign pixBus = {pixBlue, pixGreen, pixRed};

  psearch_ctrl #(
    .PHASE_W(PHASE_W), .FAST_DWELL(FAST_DWELL), .SLOW_DWELL(SLOW_DWELL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .vsync(vsync), .start(start),
    .slowMode(slowMode), .syncUpdate(syncUpdate), .bestPhase(bestPhase),
    .ctl(ctl), .curPhase(curPhase), .phaseCode(phaseCode), .busy(busy), .done(done)
  );

  psearch_dp #(
    .PIX_W(PIX_W), .PHASE_W(PHASE_W), .ACC_W(ACC_W), .N_COL(3)
  ) uDp (
    .clk(clk), .rstN(rstN), .softRst(softRst), .ctl(ctl), .pixValid(pixValid),
    .pix(pixBus), .colorDis(colorDis), .pickWorst(pickWorst),
    .curPhase(curPhase), .bestPhase(bestPhase)
  );

endmodule

// File: rtl/psearch_chk.sv
module psearch_chk #(
  parameter int PHASE_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               softRst,
  input logic               vsync,
  input logic               start,
  input logic               syncUpdate,
  input logic [PHASE_W-1:0] phaseCode,
  input logic               busy,
  input logic               done
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_DONE_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R10

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !softRst) |=> busy); // R1

  AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!busy && !done && phaseCode == '0)); // R11

  AST_DEFER_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    ((phaseCode != $past(phaseCode)) && $past(syncUpdate) && !$past(softRst))
      |-> ($past(vsync) && !$past(vsync, 2))); // R9

  AST_SWEEP_ASCEND: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (busy && (phaseCode != $past(phaseCode)) && !$past(softRst))
      |-> (phaseCode == '0 || phaseCode == PHASE_W'($past(phaseCode) + 1'b1))); // R1

endmodule

bind phase_search psearch_chk #(.PHASE_W(PHASE_W)) uChk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .vsync(vsync), .start(start),
  .syncUpdate(syncUpdate), .phaseCode(phaseCode), .busy(busy), .done(done)
);

// File: tb/tb_phase_search.sv
`timescale 1ns/1ps
module tb_phase_search;

  localparam int VP   = 10;   // clocks per vsync interval
  localparam int FAST = 28;
  localparam int SLOW = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       softRst = 1'b0;
  logic       vsync = 1'b0;
  logic       pixValid = 1'b0;
  logic [9:0] pixRed = '0, pixGreen = '0, pixBlue = '0;
  logic [2:0] colorDis = '0;
  logic       start = 1'b0;
  logic       pickWorst = 1'b0;
  logic       slowMode = 1'b0;
  logic       syncUpdate = 1'b1;
  logic [4:0] phaseCode;
  logic       busy, done;

  int total = 0;
  int bad = 0;
  int tick = 0;
  int pat = 0;
  bit tog = 0;

  bit monOn = 0;
  bit monV = 0;
  bit busyBefore = 0;
  bit prevDone = 0;
  int lastPh = 0;
  int riseCnt, incCnt, deferBad, doneCnt, doneWide, donePh, doneBusy;

  always #5 clk = ~clk;

  phase_search dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .vsync(vsync), .pixValid(pixValid),
    .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue), .colorDis(colorDis),
    .start(start), .pickWorst(pickWorst), .slowMode(slowMode), .syncUpdate(syncUpdate),
    .phaseCode(phaseCode), .busy(busy), .done(done)
  );

  function automatic int amp(int p, int c, int pt);
    case (pt)
      0: return ((p * (5 + 2 * c) + 3 * c) % 17) + 1;
      1: return (p == 9 || p == 22) ? 2 : (5 + c);
      default: return (c == 0) ? ((p == 4) ? 300 : 1) : (((p * 3) % 11) + 1);
    endcase
  endfunction

  // stimulus: vsync high for 2 clocks, six valid pixels per interval
  always @(negedge clk) begin
    if (rstN) begin
      int ph;
      tick = tick + 1;
      ph = tick % VP;
      vsync = (ph < 2);
      pixValid = (ph >= 3 && ph <= 8);
      if (pixValid) begin
        tog = ~tog;
        pixRed   = 10'(400 + (tog ? amp(int'(phaseCode), 0, pat) : 0));
        pixGreen = 10'(400 + (tog ? amp(int'(phaseCode), 1, pat) : 0));
        pixBlue  = 10'(400 + (tog ? amp(int'(phaseCode), 2, pat) : 0));
      end
    end
  end

  // output monitor, sampled 1 ns after the active edge
  always @(posedge clk) begin
    #1;
    if (monOn) begin
      bit rise;
      rise = vsync && !monV;
      if (rise && busyBefore) riseCnt++;
      if (int'(phaseCode) != lastPh) begin
        if (int'(phaseCode) == lastPh + 1) incCnt++;
        if (syncUpdate && !rise) deferBad++;
      end
      if (done) begin
        doneCnt++;
        donePh = int'(phaseCode);
        doneBusy = int'(busy);
        if (prevDone) doneWide++;
      end
    end
    monV = vsync;
    busyBefore = busy;
    lastPh = int'(phaseCode);
    prevDone = done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic alignMid();
    @(posedge clk);
    while ((tick % VP) != 5) @(posedge clk);
  endtask

  task automatic runSearch(input int pt, input bit worst, input bit slow,
                           input bit defer, input logic [2:0] dis, input string req);
    int expPh, bestM, m, n, expRise;
    expPh = 0; bestM = 0;
    for (int p = 0; p < 32; p++) begin
      m = 0;
      for (int c = 0; c < 3; c++) if (!dis[c]) m += amp(p, c, pt);
      if (p == 0 || (worst ? (m > bestM) : (m < bestM))) begin
        bestM = m;
        expPh = p;
      end
    end
    n = slow ? SLOW : FAST;
    expRise = defer ? (32 * (n + 1) + 1) : (32 * n);
    pat = pt; pickWorst = worst; slowMode = slow; syncUpdate = defer; colorDis = dis;
    alignMid();
    riseCnt = 0; incCnt = 0; deferBad = 0; doneCnt = 0; doneWide = 0;
    monOn = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    while (doneCnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    monOn = 0;
    chk(donePh == expPh, req, donePh, expPh);
    chk(int'(phaseCode) == expPh, "R10 phase held after done", int'(phaseCode), expPh);
    chk(doneCnt == 1 && doneWide == 0, "R10 done single pulse", doneCnt, 1);
    chk(doneBusy == 0, "R10 busy low with done", doneBusy, 0);
    chk(incCnt == 31, "R1 ascending sweep steps", incCnt, 31);
    chk(riseCnt == expRise, defer ? "R9 R2 busy span in edges" : "R8 R2 busy span in edges",
        riseCnt, expRise);
    if (defer) chk(deferBad == 0, "R9 change off vsync edge", deferBad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(phaseCode == 5'd0, "R12 reset phase", int'(phaseCode), 0);
    chk(busy == 1'b0, "R12 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R12 reset done", int'(done), 0);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(phaseCode == 5'd0 && !busy && !done, "R12 idle after release", int'(busy), 0);

    // R4 R3: smallest metric, immediate, fast
    runSearch(0, 1'b0, 1'b0, 1'b0, 3'b000, "R4 R3 best phase");
    // R5: largest metric, deferred updates
    runSearch(0, 1'b1, 1'b0, 1'b1, 3'b000, "R5 worst phase deferred");
    // R6: two codes tie at the minimum
    runSearch(1, 1'b0, 1'b0, 1'b0, 3'b000, "R6 tie keeps lower code");
    // R7: red disabled, its spike at code 4 must not win
    runSearch(2, 1'b1, 1'b0, 1'b0, 3'b001, "R7 disabled colour ignored");
    // R2: slow dwell
    runSearch(0, 1'b0, 1'b1, 1'b0, 3'b000, "R2 slow mode result");

    // R11: soft reset mid-search, then soft reset together with start
    pat = 0; pickWorst = 1'b0; slowMode = 1'b0; syncUpdate = 1'b0; colorDis = 3'b000;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2000) @(negedge clk);
    chk(busy == 1'b1 && int'(phaseCode) > 0, "R11 search running before soft reset",
        int'(phaseCode), 1);
    softRst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && phaseCode == 5'd0, "R11 held idle in soft reset",
        int'(phaseCode), 0);
    start = 1'b1;
    repeat (2) @(negedge clk);
    softRst = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11 start ignored during soft reset", int'(busy), 0);
    chk(phaseCode == 5'd0, "R11 phase stays 0", int'(phaseCode), 0);
    runSearch(2, 1'b0, 1'b0, 1'b1, 3'b000, "R11 search after soft reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule